// File: doc/BRIEF.md
# GPIO Interrupt Slot Selector

This block routes a chosen few of a large set of general-purpose input pins onto a fixed pool of 32 interrupt slots. Each slot owns a selector byte that names one pin and carries an enable flag. It also has a 2-bit sense mode that decides what on that pin counts as an event: a rising edge, a falling edge, a high level or a low level. Each slot keeps one status bit. It drives its own active-high level interrupt line toward a parent interrupt controller.

Every pin passes through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier. In the edge modes a detected event sets the status bit, and the bit stays set until software clears it. In the level modes the status bit tracks the active level. Software reaches the block through a simple 32-bit register bus: an address, a write strobe, write data, and combinational read data. Through it software programs selectors and sense modes, reads status and clears status bits by writing zeros.

Top module: `gpio_slot_irq`

## Requirements
- R1: After reset all status bits, selector bytes and sense modes are zero, every `irqOut` line is low and every register reads 0.
- R2: Slot n has a selector byte at byte lane (n mod 4) of the word at offset 0x30 + 4*(n/4), so the words run 0x30..0x4C. Bit 7 of the byte is the slot enable and bits 6:0 are the pin number. Every selector word reads back exactly as written.
- R3: Sense modes take 2 bits per slot: 0 rising edge, 1 falling edge, 2 high level, 3 low level. Slots 0..15 sit in the word at 0x24 and slots 16..31 in the word at 0x28, with slot k (mod 16) at bits [2k+1:2k]. Both words read back as written.
- R4: In rising-edge mode, a pin rise applied before clock edge N sets the slot's status bit and `irqOut` after edge N+2, not earlier. The bit stays set until it is cleared.
- R5: In falling-edge mode only a pin fall sets the status bit, with the same latency as R4. A rise has no effect.
- R6: In the level modes the status bit follows the active level with the R4 latency. A clear written while the level is still active leaves the bit set.
- R7: The status word at 0x20 holds bit n for slot n. Writing 0 to a bit clears it. Writing 1 has no effect.
- R8: If a detected event and a clear of the same slot fall in the same cycle, the status bit ends set.
- R9: A slot whose enable bit is 0 never sets its status bit. `irqOut[n]` is status bit n AND'ed with the slot enable, so disabling a slot masks its line without losing its status.
- R10: A pin number at or above NUM_PINS selects a constant low input.
- R11: Offsets 0x10 and 0x14 (reserved for the dedicated-pin registers) and all other unmapped offsets read 0. Writes to them change nothing.
- R12: Each `irqOut` line is an active-high level that stays asserted while the slot's status bit and enable are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gpioIn | input | NUM_PINS | Asynchronous general-purpose pin inputs |
| regAddr | input | ADDR_W | Register byte address, word aligned |
| regWrEn | input | 1 | Write strobe, one write per cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| irqOut | output | 32 | Per-slot active-high level interrupts |

## Verification
The bench builds the block with NUM_PINS = 123 and ADDR_W = 8. With 123 pins, the selector codes 123 to 127 point at pins that do not exist, so the constant-low path of the selection multiplexer is reached by ordinary register writes. The 8-bit address covers the reserved, status, sense and all eight selector words. Random traffic concentrates selectors on a handful of toggling pins plus the out-of-range codes. This makes edges, level changes, clears that coincide with events, and enable changes on active slots occur many times.

// File: rtl/gpio_slot_pkg.sv
package gpio_slot_pkg;
  localparam int NUM_SLOTS      = 32;
  localparam int SEL_W          = 8;
  localparam int PIN_W          = SEL_W - 1;
  localparam int SLOTS_PER_WORD = 32 / SEL_W;
  localparam int SEL_WORDS      = NUM_SLOTS / SLOTS_PER_WORD;
  localparam int IDX_W          = $clog2(SEL_WORDS);
  localparam int SENSE_PER_WORD = 16;
  localparam int SPW_W          = $clog2(SENSE_PER_WORD);
  localparam int SPB_W          = $clog2(SLOTS_PER_WORD);

  localparam int RSV0_OFF   = 'h10;
  localparam int RSV1_OFF   = 'h14;
  localparam int STATUS_OFF = 'h20;
  localparam int SENSE0_OFF = 'h24;
  localparam int SENSE1_OFF = 'h28;
  localparam int SEL_BASE   = 'h30;
  localparam int SEL_END    = SEL_BASE + 4 * SEL_WORDS;

  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_STATUS,
    RD_SENSE,
    RD_SEL
  } rdsel_e;

  typedef struct packed {
    logic [SEL_WORDS-1:0] selWr;
    logic [1:0]           senseWr;
    logic                 statusWr;
    rdsel_e               rdSel;
    logic [IDX_W-1:0]     rdIdx;
  } strobes_t;
endpackage

// File: rtl/gpio_slot_ctrl.sv
module gpio_slot_ctrl
  import gpio_slot_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobes_t          st
);
  logic [ADDR_W-1:0] selOff;

  assign selOff = regAddr - ADDR_W'(SEL_BASE);

  always_comb begin
    st       = '0;
    st.rdSel = RD_ZERO;
    if (regAddr[1:0] == 2'b00) begin
      if (regAddr == ADDR_W'(STATUS_OFF)) begin
        st.rdSel    = RD_STATUS;
        st.statusWr = regWrEn;
      end else if (regAddr == ADDR_W'(SENSE0_OFF)) begin
        st.rdSel      = RD_SENSE;
        st.rdIdx      = '0;
        st.senseWr[0] = regWrEn;
      end else if (regAddr == ADDR_W'(SENSE1_OFF)) begin
        st.rdSel      = RD_SENSE;
        st.rdIdx      = IDX_W'(1);
        st.senseWr[1] = regWrEn;
      end else if (regAddr >= ADDR_W'(SEL_BASE) && regAddr < ADDR_W'(SEL_END)) begin
        st.rdSel                   = RD_SEL;
        st.rdIdx                   = selOff[2 +: IDX_W];
        st.selWr[selOff[2 +: IDX_W]] = regWrEn;
      end
    end
  end

  // R11
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.selWr, st.senseWr, st.statusWr}));
endmodule

// File: rtl/gpio_slot_dp.sv
module gpio_slot_dp
  import gpio_slot_pkg::*;
#(
  parameter int NUM_PINS = 123
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PINS-1:0]  gpioIn,
  input  logic [31:0]          wrData,
  input  strobes_t             st,
  output logic [31:0]          rdData,
  output logic [NUM_SLOTS-1:0] irqOut
);
  localparam int PIN_SPACE = 1 << PIN_W;

  logic [NUM_PINS-1:0]  syncA, syncB, prevB;
  logic [PIN_SPACE-1:0] curPad, prvPad;
  logic [SEL_W-1:0]     selByte   [NUM_SLOTS];
  sense_e               senseMode [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] status, statusNext, slotEn, setHit, clrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= gpioIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign curPad = PIN_SPACE'(syncB);
  assign prvPad = PIN_SPACE'(prevB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        selByte[i]   <= '0;
        senseMode[i] <= SENSE_RISE;
      end
    end else begin
      for (int w = 0; w < SEL_WORDS; w++)
        if (st.selWr[w])
          for (int b = 0; b < SLOTS_PER_WORD; b++)
            selByte[SLOTS_PER_WORD*w + b] <= wrData[SEL_W*b +: SEL_W];
      for (int h = 0; h < 2; h++)
        if (st.senseWr[h])
          for (int k = 0; k < SENSE_PER_WORD; k++)
            senseMode[SENSE_PER_WORD*h + k] <= sense_e'(wrData[2*k +: 2]);
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [PIN_W-1:0] pinIdx;
    logic             curV, prvV, hit;

    assign pinIdx    = selByte[i][PIN_W-1:0];
    assign slotEn[i] = selByte[i][SEL_W-1];
    assign curV      = curPad[pinIdx];
    assign prvV      = prvPad[pinIdx];

    always_comb begin
      unique case (senseMode[i])
        SENSE_RISE: hit = curV & ~prvV;
        SENSE_FALL: hit = ~curV & prvV;
        SENSE_HIGH: hit = curV;
        default:    hit = ~curV;
      endcase
    end

    assign setHit[i]     = slotEn[i] & hit;
    assign clrHit[i]     = st.statusWr & ~wrData[i];
    assign statusNext[i] = setHit[i] | (status[i] & ~senseMode[i][1] & ~clrHit[i]);

    // R9
    no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      !slotEn[i] |=> !(status[i] && !$past(status[i])));
    // R4
    edge_latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (status[i] && !senseMode[i][1] && !st.statusWr) |=> status[i]);
    // R8
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (clrHit[i] && setHit[i]) |=> status[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= statusNext;
  end

  assign irqOut = status & slotEn;

  always_comb begin
    rdData = '0;
    unique case (st.rdSel)
      RD_STATUS: rdData = status;
      RD_SENSE:
        for (int k = 0; k < SENSE_PER_WORD; k++)
          rdData[2*k +: 2] = senseMode[{st.rdIdx[0], SPW_W'(k)}];
      RD_SEL:
        for (int b = 0; b < SLOTS_PER_WORD; b++)
          rdData[SEL_W*b +: SEL_W] = selByte[{st.rdIdx, SPB_W'(b)}];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_slot_irq.sv
module gpio_slot_irq
  import gpio_slot_pkg::*;
#(
  parameter int NUM_PINS = 123,
  parameter int ADDR_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PINS-1:0]  gpioIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic [NUM_SLOTS-1:0] irqOut
);
  strobes_t st;

  gpio_slot_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .st      (st)
  );

  gpio_slot_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .gpioIn (gpioIn),
    .wrData (regWrData),
    .st     (st),
    .rdData (regRdData),
    .irqOut (irqOut)
  );

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(RSV0_OFF) || regAddr == ADDR_W'(RSV1_OFF)) |-> regRdData == '0);
endmodule

// File: tb/gpio_slot_irq_test.sv
module gpio_slot_irq_test;
  localparam int NP = 123;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] gpio = '0;
  logic [AW-1:0] regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [31:0]   irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  gpio_slot_irq #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .gpioIn(gpio), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irq)
  );

  // Reference model built from the requirements
  logic [NP-1:0] m1, m2, mp;
  logic [7:0]    msel [32];
  logic [1:0]    msense [32];
  logic [31:0]   mstat;

  function automatic logic [31:0] enVec();
    logic [31:0] e;
    for (int i = 0; i < 32; i++) e[i] = msel[i][7];
    return e;
  endfunction

  function automatic logic [31:0] calcStat();
    logic [31:0]  n;
    logic [127:0] c, p;
    logic         cv, pv, s, clr, hold;
    c = 128'(m2);
    p = 128'(mp);
    for (int i = 0; i < 32; i++) begin
      cv = c[msel[i][6:0]];
      pv = p[msel[i][6:0]];
      case (msense[i])
        2'd0: s = cv & ~pv;
        2'd1: s = ~cv & pv;
        2'd2: s = cv;
        default: s = ~cv;
      endcase
      s    = s & msel[i][7];
      clr  = regWrEn && regAddr == 8'h20 && !regWrData[i];
      hold = !msense[i][1] && mstat[i];
      n[i] = s | (hold & ~clr);
    end
    return n;
  endfunction

  function automatic logic [31:0] expRead(logic [7:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 8'h20) r = mstat;
    else if (a == 8'h24) for (int k = 0; k < 16; k++) r[2*k +: 2] = msense[k];
    else if (a == 8'h28) for (int k = 0; k < 16; k++) r[2*k +: 2] = msense[16+k];
    else if (a >= 8'h30 && a < 8'h50 && a[1:0] == 2'b00)
      for (int b = 0; b < 4; b++) r[8*b +: 8] = msel[4*((a - 8'h30) >> 2) + b];
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= '0; m2 <= '0; mp <= '0; mstat <= '0;
      for (int i = 0; i < 32; i++) begin msel[i] <= '0; msense[i] <= '0; end
    end else begin
      m1 <= gpio; m2 <= m1; mp <= m2;
      mstat <= calcStat();
      if (regWrEn) begin
        if (regAddr == 8'h24) for (int k = 0; k < 16; k++) msense[k] <= regWrData[2*k +: 2];
        if (regAddr == 8'h28) for (int k = 0; k < 16; k++) msense[16+k] <= regWrData[2*k +: 2];
        if (regAddr >= 8'h30 && regAddr < 8'h50 && regAddr[1:0] == 2'b00)
          for (int b = 0; b < 4; b++) msel[4*((regAddr - 8'h30) >> 2) + b] <= regWrData[8*b +: 8];
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    check("R12 irq vs model", irq, mstat & enVec());
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
  endtask

  task automatic rdModel(logic [7:0] a, string req);
    regAddr = a; regWrEn = 1'b0;
    #1;
    check(req, regRdData, expRead(a));
  endtask

  task automatic rdLit(logic [7:0] a, logic [31:0] exp, string req);
    regAddr = a; regWrEn = 1'b0;
    #1;
    check(req, regRdData, exp);
  endtask

  function automatic logic [7:0] rndSel();
    logic [6:0] p;
    if ($urandom % 4 == 0) p = 7'($urandom_range(127, 118));
    else                   p = 7'($urandom_range(15, 0));
    return {1'($urandom % 2), p};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", irq, 32'h0);
    rdLit(8'h20, 32'h0, "R1 status");
    rdLit(8'h24, 32'h0, "R1 sense0");
    rdLit(8'h28, 32'h0, "R1 sense1");
    rdLit(8'h30, 32'h0, "R1 sel word0");
    rdLit(8'h4C, 32'h0, "R1 sel word7");

    // R2 selector packing: slot4 pin1 off, slot5 pin3 on, slot6 pin10 on, slot7 pin11 off
    wr(8'h34, 32'h0B8A8301);
    rdLit(8'h34, 32'h0B8A8301, "R2 selector readback");

    // R4 rising latency on slot 6
    gpio[10] = 1'b1;
    ticks(2);
    check("R4 not before edge N+2", 32'(irq[6]), 32'h0);
    tick();
    check("R4 set after edge N+2", 32'(irq[6]), 32'h1);

    // R3 / R5 falling mode on slot 5
    wr(8'h24, 32'h0000_0400);
    rdLit(8'h24, 32'h0000_0400, "R3 sense field slot5");
    gpio[3] = 1'b1;
    ticks(3);
    check("R5 rise ignored", 32'(irq[5]), 32'h0);
    gpio[3] = 1'b0;
    ticks(2);
    check("R5 not early", 32'(irq[5]), 32'h0);
    tick();
    check("R5 fall sets", 32'(irq[5]), 32'h1);

    // R7 clearing
    wr(8'h20, ~(32'h1 << 5));
    check("R7 zero clears", {30'h0, irq[6], irq[5]}, 32'h2);
    wr(8'h20, 32'hFFFF_FFFF);
    check("R7 one no effect", {30'h0, irq[6], irq[5]}, 32'h2);

    // R9 disabled slots
    gpio[1] = 1'b1; gpio[11] = 1'b1;
    ticks(4);
    rdLit(8'h20, 32'h0000_0040, "R9 disabled slots stay clear");
    wr(8'h34, 32'h0B8A8381);
    ticks(4);
    check("R9 late enable no event", 32'(irq[4]), 32'h0);
    wr(8'h34, 32'h0B0A8381);
    check("R9 mask line", 32'(irq[6]), 32'h0);
    rdLit(8'h20, 32'h0000_0040, "R9 status kept while masked");
    wr(8'h34, 32'h0B8A8381);
    check("R9 unmask line", 32'(irq[6]), 32'h1);

    // R8 set wins over simultaneous clear on slot 6
    gpio[10] = 1'b0;
    wr(8'h20, ~(32'h1 << 6));
    ticks(3);
    check("R8 precondition cleared", 32'(irq[6]), 32'h0);
    gpio[10] = 1'b1;
    ticks(2);
    wr(8'h20, ~(32'h1 << 6));
    check("R8 set beats clear", 32'(irq[6]), 32'h1);

    // R6 level-high on slot 16, pin 20
    wr(8'h40, 32'h0000_0094);
    wr(8'h28, 32'h0000_0002);
    rdLit(8'h28, 32'h0000_0002, "R3 sense field slot16");
    gpio[20] = 1'b1;
    ticks(2);
    check("R6 level not early", 32'(irq[16]), 32'h0);
    tick();
    check("R6 level sets", 32'(irq[16]), 32'h1);
    wr(8'h20, ~(32'h1 << 16));
    check("R6 clear while active", 32'(irq[16]), 32'h1);
    gpio[20] = 1'b0;
    ticks(2);
    check("R6 still high", 32'(irq[16]), 32'h1);
    tick();
    check("R6 follows level", 32'(irq[16]), 32'h0);

    // R10 out-of-range pin 125 on slot 8 in low-level mode
    wr(8'h38, 32'h0000_00FD);
    ticks(2);
    check("R10 rising never fires", 32'(irq[8]), 32'h0);
    wr(8'h24, 32'h0003_0400);
    ticks(2);
    check("R10 reads low", 32'(irq[8]), 32'h1);

    // R11 reserved and unmapped offsets
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    rdLit(8'h10, 32'h0, "R11 reserved 0x10");
    rdLit(8'h14, 32'h0, "R11 reserved 0x14");
    rdLit(8'h2C, 32'h0, "R11 unmapped 0x2C");
    rdLit(8'h24, 32'h0003_0400, "R11 sense untouched");
    rdLit(8'h34, 32'h0B8A8381, "R11 selector untouched");

    // R12 level held
    for (int i = 0; i < 8; i++) begin
      tick();
      check("R12 line held", 32'(irq[8]), 32'h1);
    end

    // Random phase: R4 R5 R6 R7 R8 R9 R10 against the model
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int j = 0; j < 3; j++)
        if ($urandom % 3 == 0) gpio[$urandom_range(15, 0)] ^= 1'b1;
      if ($urandom % 6 == 0) begin
        int pick;
        logic [7:0] a;
        pick = $urandom_range(11, 0);
        if (pick < 8) begin
          a = 8'(8'h30 + 4 * pick);
          wr(a, {rndSel(), rndSel(), rndSel(), rndSel()});
        end else if (pick == 8) wr(8'h24, $urandom);
        else if (pick == 9) wr(8'h28, $urandom);
        else if (pick == 10) wr(8'h20, ~(32'h1 << $urandom_range(31, 0)));
        else wr(8'h10, $urandom);
      end else begin
        tick();
      end
      if (cyc % 8 == 0) begin
        logic [7:0] ra;
        ra = 8'(4 * $urandom_range(19, 4));
        rdModel(ra, "R7 random readback");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule